// File: doc/BRIEF.md
# External Bus Master Strobe Generator

This block is the master end of a 64-bit external memory bus. A requester hands it one transaction at a time: a 32-bit word address, a read or write flag, an access width of 32 or 64 bits, a flag that marks the target zone as 32 bits wide, a beat count for bursts, and write data. The block turns that into bus cycles. It drives the address, a read strobe, separate low-lane and high-lane write strobes, two decoded bank selects, a host-space select and a burst flag. A slave can stretch any data phase by holding acknowledge low.

All bus outputs come from one set of registers, so the address, the strobes and the decoded selects change together. During a burst the address steps forward after each acknowledged beat. A write burst pulls its next data word from the requester through a one-cycle pull strobe. Every completed beat is reported back with a registered valid pulse and the captured read data, and the final beat is flagged. The bus always rests for at least one idle cycle between transactions.

Top module: `extbus_master`

## Requirements
- R1: `busBank[0]` is high exactly when a strobe is active and address bits 31:27 equal 0b00110, and `busBank[1]` is high exactly when a strobe is active and those bits equal 0b00111. Both are low when the bus is idle.
- R2: `busHost` is high exactly when a strobe is active and address bit 31 is 1.
- R3: A request accepted at a clock edge (`reqValid` high while `reqReady` is high) puts its address, strobes and selects on the bus in the very next cycle, all in that same cycle.
- R4: A read asserts `busRd` alone for every beat, and `busRd` is never high together with either write strobe.
- R5: For writes, address bit 0 gives word parity (0 is even). A write to a 32-bit zone asserts only `busWrLo`. Otherwise a 64-bit write asserts both `busWrLo` and `busWrHi`, a 32-bit write to an even word asserts only `busWrLo`, and a 32-bit write to an odd word asserts only `busWrHi`.
- R6: `reqBeats` holds the beat count minus one. `busBurst` is high in every bus cycle of a transaction with more than one beat and low for single-beat transactions and when idle.
- R7: While `busAck` is sampled low during a data phase, the address, all strobes, selects and `busWdata` hold their values into the next cycle.
- R8: After each acknowledged beat that is not the last, the address grows by 1 for a 32-bit access or by 2 for a 64-bit access. After the last beat the bus goes idle: all strobes and selects drop, and the address reads zero.
- R9: `reqReady` is high only while the bus is idle. At least one idle cycle separates two transactions, even when `reqValid` stays high.
- R10: One cycle after each acknowledged beat, `rspValid` pulses. `rspLast` pulses with it on the final beat. `rspData` holds the read data sampled on the most recent acknowledged read beat.
- R11: `wrPull` is high, combinationally, exactly in a cycle where a non-final write beat is acknowledged. At that edge `reqWdata` is taken as the next beat's write data and shown on `busWdata` in the following cycle.
- R12: When `rstN` is low at a clock edge, the bus goes idle with all outputs zero and `reqReady` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to accept a request |
| reqAddr | input | 32 | Starting word address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLong | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reqZone32 | input | 1 | Target zone is 32 bits wide |
| reqBeats | input | 4 | Beat count minus one |
| reqWdata | input | 64 | First write word at acceptance, later the next burst write word |
| wrPull | output | 1 | reqWdata is consumed at this edge |
| rspValid | output | 1 | A beat completed in the previous cycle |
| rspLast | output | 1 | That beat was the final one |
| rspData | output | 64 | Most recently captured read data |
| busAddr | output | 32 | Bus address |
| busRd | output | 1 | Read strobe |
| busWrLo | output | 1 | Low-lane write strobe |
| busWrHi | output | 1 | High-lane write strobe |
| busBank | output | 2 | Decoded bank selects |
| busHost | output | 1 | Host-space select |
| busBurst | output | 1 | Consecutive-address transfer in progress |
| busWdata | output | 64 | Write data, zero when not writing |
| busRdata | input | 64 | Read data from the slave |
| busAck | input | 1 | Slave acknowledge, low inserts a wait state |

## Verification
A wrong beat counter shows up as an extra or missing cycle of strobes and a misplaced `rspLast`. A wrong address step shows up on `busAddr` and on the bank selects one cycle after an acknowledged beat. A wait-state fault moves the address or data during a cycle where acknowledge was low, which shows up on the very next cycle. The bench runs a behavioural model beside the design and compares every port on every clock, so any such divergence is reported in the cycle it first appears on the pins.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
  // Control to datapath strobes, one cycle's worth.
  typedef struct packed {
    logic active;   // a data phase is on the bus
    logic load;     // take a new request
    logic advance;  // non-final beat acknowledged: step address, refill data
    logic capture;  // any beat acknowledged
  } dpCtl_t;
endpackage

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
#(
  parameter int BeatW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [BeatW-1:0] reqBeats,
  input  logic             busAck,
  output logic             reqReady,
  output dpCtl_t           ctl,
  output logic             busBurst,
  output logic             rspValid,
  output logic             rspLast
);
  typedef enum logic {StIdle, StData} state_t;

  state_t           stQ;
  logic [BeatW-1:0] leftQ;
  logic             burstQ;
  logic             beatEnd;
  logic             lastBeat;

  always_comb begin
    beatEnd     = (stQ == StData) && busAck;
    lastBeat    = (leftQ == '0);
    ctl.active  = (stQ == StData);
    ctl.load    = (stQ == StIdle) && reqValid;
    ctl.advance = beatEnd && !lastBeat;
    ctl.capture = beatEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ      <= StIdle;
      leftQ    <= '0;
      burstQ   <= 1'b0;
      rspValid <= 1'b0;
      rspLast  <= 1'b0;
    end else begin
      rspValid <= beatEnd;
      rspLast  <= beatEnd && lastBeat;
      if (ctl.load) begin
        stQ    <= StData;
        leftQ  <= reqBeats;
        burstQ <= (reqBeats != '0);
      end else if (ctl.advance) begin
        leftQ <= leftQ - 1'b1;
      end else if (beatEnd && lastBeat) begin
        stQ    <= StIdle;
        burstQ <= 1'b0;
      end
    end
  end

  assign reqReady = (stQ == StIdle);
  assign busBurst = ctl.active && burstQ;
endmodule

// File: rtl/extbus_dpath.sv
module extbus_dpath
  import extbus_pkg::*;
#(
  parameter int AddrW    = 32,
  parameter int DataW    = 64,
  parameter int NumBanks = 2,
  parameter int BankBase = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic [AddrW-1:0]    reqAddr,
  input  logic                reqWrite,
  input  logic                reqLong,
  input  logic                reqZone32,
  input  logic [DataW-1:0]    reqWdata,
  input  logic [DataW-1:0]    busRdata,
  output logic [AddrW-1:0]    busAddr,
  output logic                busRd,
  output logic                busWrLo,
  output logic                busWrHi,
  output logic [NumBanks-1:0] busBank,
  output logic                busHost,
  output logic [DataW-1:0]    busWdata,
  output logic [DataW-1:0]    rspData,
  output logic                wrPull
);
  localparam int SelW = 5;

  logic [AddrW-1:0] addrQ;
  logic [DataW-1:0] wdataQ;
  logic [DataW-1:0] rdQ;
  logic             writeQ;
  logic             longQ;
  logic             zoneQ;
  logic [AddrW-1:0] stepVal;

  assign stepVal = longQ ? AddrW'(2) : AddrW'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdQ    <= '0;
      writeQ <= 1'b0;
      longQ  <= 1'b0;
      zoneQ  <= 1'b0;
    end else begin
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        writeQ <= reqWrite;
        longQ  <= reqLong;
        zoneQ  <= reqZone32;
      end else if (ctl.advance) begin
        addrQ <= addrQ + stepVal;
        if (writeQ) wdataQ <= reqWdata;
      end
      if (ctl.capture && !writeQ) rdQ <= busRdata;
    end
  end

  always_comb begin
    busAddr  = ctl.active ? addrQ : '0;
    busRd    = ctl.active && !writeQ;
    busWrLo  = ctl.active && writeQ && (zoneQ || longQ || !addrQ[0]);
    busWrHi  = ctl.active && writeQ && !zoneQ && (longQ || addrQ[0]);
    busHost  = ctl.active && addrQ[AddrW-1];
    busWdata = (ctl.active && writeQ) ? wdataQ : '0;
    wrPull   = ctl.advance && writeQ;
    rspData  = rdQ;
  end

  for (genvar g = 0; g < NumBanks; g++) begin : gBank
    assign busBank[g] = ctl.active && (addrQ[AddrW-1 -: SelW] == SelW'(BankBase + g));
  end
endmodule

// File: rtl/extbus_master.sv
module extbus_master
  import extbus_pkg::*;
#(
  parameter int AddrW = 32,
  parameter int DataW = 64,
  parameter int BeatW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [AddrW-1:0] reqAddr,
  input  logic             reqWrite,
  input  logic             reqLong,
  input  logic             reqZone32,
  input  logic [BeatW-1:0] reqBeats,
  input  logic [DataW-1:0] reqWdata,
  output logic             wrPull,
  output logic             rspValid,
  output logic             rspLast,
  output logic [DataW-1:0] rspData,
  output logic [AddrW-1:0] busAddr,
  output logic             busRd,
  output logic             busWrLo,
  output logic             busWrHi,
  output logic [1:0]       busBank,
  output logic             busHost,
  output logic             busBurst,
  output logic [DataW-1:0] busWdata,
  input  logic [DataW-1:0] busRdata,
  input  logic             busAck
);
  dpCtl_t ctl;

  extbus_ctrl #(.BeatW(BeatW)) ctrlInst (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBeats(reqBeats),
    .busAck(busAck), .reqReady(reqReady), .ctl(ctl), .busBurst(busBurst),
    .rspValid(rspValid), .rspLast(rspLast)
  );

  extbus_dpath #(.AddrW(AddrW), .DataW(DataW), .NumBanks(2), .BankBase(6)) dpInst (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqLong(reqLong), .reqZone32(reqZone32), .reqWdata(reqWdata),
    .busRdata(busRdata), .busAddr(busAddr), .busRd(busRd), .busWrLo(busWrLo),
    .busWrHi(busWrHi), .busBank(busBank), .busHost(busHost),
    .busWdata(busWdata), .rspData(rspData), .wrPull(wrPull)
  );
endmodule

// File: rtl/extbus_master_chk.sv
module extbus_master_chk #(
  parameter int AddrW = 32,
  parameter int DataW = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqReady,
  input logic             wrPull,
  input logic             rspValid,
  input logic             rspLast,
  input logic [AddrW-1:0] busAddr,
  input logic             busRd,
  input logic             busWrLo,
  input logic             busWrHi,
  input logic [1:0]       busBank,
  input logic             busHost,
  input logic             busBurst,
  input logic [DataW-1:0] busWdata,
  input logic             busAck
);
  logic anyS;
  assign anyS = busRd || busWrLo || busWrHi;

  AST_BANK0_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    anyS |-> (busBank[0] == (busAddr[AddrW-1 -: 5] == 5'b00110))); // R1
  AST_BANK1_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    anyS |-> (busBank[1] == (busAddr[AddrW-1 -: 5] == 5'b00111))); // R1
  AST_HOST_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    anyS |-> (busHost == busAddr[AddrW-1])); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !anyS |-> (busBank == 2'b00 && !busHost && !busBurst && busAddr == '0)); // R8
  AST_READ_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && (busWrLo || busWrHi))); // R4
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (anyS && !busAck) |=> ($stable(busAddr) && $stable(busRd) && $stable(busWrLo)
      && $stable(busWrHi) && $stable(busBank) && $stable(busWdata))); // R7
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (anyS && busBurst && busAck) |=> (!anyS || busAddr != $past(busAddr))); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !anyS); // R9
  AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    rspLast |-> !anyS); // R9
  AST_BEAT_REPORT: assert property (@(posedge clk) disable iff (!rstN)
    (anyS && busAck) |=> rspValid); // R10
  AST_PULL_CONTEXT: assert property (@(posedge clk) disable iff (!rstN)
    wrPull |-> (busAck && (busWrLo || busWrHi) && busBurst)); // R11
endmodule

bind extbus_master extbus_master_chk #(.AddrW(AddrW), .DataW(DataW)) chkInst (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .wrPull(wrPull),
  .rspValid(rspValid), .rspLast(rspLast), .busAddr(busAddr), .busRd(busRd),
  .busWrLo(busWrLo), .busWrHi(busWrHi), .busBank(busBank), .busHost(busHost),
  .busBurst(busBurst), .busWdata(busWdata), .busAck(busAck)
);

// File: tb/extbus_master_test.sv
module extbus_master_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqReady;
  logic [31:0] reqAddr;
  logic        reqWrite, reqLong, reqZone32;
  logic [3:0]  reqBeats;
  logic [63:0] reqWdata;
  logic        wrPull, rspValid, rspLast;
  logic [63:0] rspData;
  logic [31:0] busAddr;
  logic        busRd, busWrLo, busWrHi, busHost, busBurst;
  logic [1:0]  busBank;
  logic [63:0] busWdata, busRdata;
  logic        busAck;

  always #4ns clk = ~clk;

  extbus_master uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqLong(reqLong),
    .reqZone32(reqZone32), .reqBeats(reqBeats), .reqWdata(reqWdata),
    .wrPull(wrPull), .rspValid(rspValid), .rspLast(rspLast), .rspData(rspData),
    .busAddr(busAddr), .busRd(busRd), .busWrLo(busWrLo), .busWrHi(busWrHi),
    .busBank(busBank), .busHost(busHost), .busBurst(busBurst),
    .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Scripted transactions
  localparam int NReq = 10;
  logic [31:0] rqAddr  [NReq];
  logic        rqWr    [NReq];
  logic        rqLong  [NReq];
  logic        rqZone  [NReq];
  int          rqBeats [NReq];

  function automatic logic [63:0] wd(int idx, int beat);
    return {32'hC0DE0000 | 32'(idx), 32'(beat) * 32'h11111111};
  endfunction

  // Behavioural reference state
  bit          mBusy = 0, mWr = 0, mLong = 0, mZone = 0, mBurst = 0;
  bit          mRv = 0, mRl = 0, mFirst = 0;
  logic [31:0] mAddr = '0;
  logic [63:0] mWd = '0, mRd = '0;
  int          mLeft = 0, mBeat = 0, curIdx = 0, head = 0;

  task automatic compareAll();
    logic        eRd, eLo, eHi;
    logic [1:0]  eBank;
    eRd = mBusy && !mWr;
    eLo = mBusy && mWr && (mZone || mLong || !mAddr[0]);
    eHi = mBusy && mWr && !mZone && (mLong || mAddr[0]);
    eBank[0] = mBusy && (mAddr[31:27] == 5'b00110);
    eBank[1] = mBusy && (mAddr[31:27] == 5'b00111);
    chk("R1", "busBank", 64'(busBank), 64'(eBank));
    chk("R2", "busHost", 64'(busHost), 64'(mBusy && mAddr[31]));
    chk("R4", "busRd", 64'(busRd), 64'(eRd));
    chk("R5", "busWrLo", 64'(busWrLo), 64'(eLo));
    chk("R5", "busWrHi", 64'(busWrHi), 64'(eHi));
    chk("R6", "busBurst", 64'(busBurst), 64'(mBusy && mBurst));
    chk("R8", "busAddr", 64'(busAddr), 64'(mBusy ? mAddr : 32'h0));
    chk("R11", "busWdata", busWdata, (mBusy && mWr) ? mWd : 64'h0);
    chk("R9", "reqReady", 64'(reqReady), 64'(!mBusy));
    chk("R10", "rspValid", 64'(rspValid), 64'(mRv));
    chk("R10", "rspLast", 64'(rspLast), 64'(mRl));
    chk("R10", "rspData", rspData, mRd);
  endtask

  task automatic modelStep();
    if (mBusy) begin
      mFirst = 0;
      if (busAck) begin
        mRv = 1;
        mRl = (mLeft == 0);
        if (!mWr) mRd = busRdata;
        if (mLeft == 0) mBusy = 0;
        else begin
          mAddr = mAddr + (mLong ? 32'd2 : 32'd1);
          mLeft--;
          mBeat++;
          if (mWr) mWd = reqWdata;
        end
      end else begin
        mRv = 0; mRl = 0;
      end
    end else begin
      mRv = 0; mRl = 0; mFirst = 0;
      if (reqValid) begin
        mBusy = 1; mFirst = 1;
        curIdx = head;
        mAddr = rqAddr[head]; mWr = rqWr[head]; mLong = rqLong[head];
        mZone = rqZone[head]; mBurst = (rqBeats[head] > 1);
        mLeft = rqBeats[head] - 1; mBeat = 0; mWd = reqWdata;
        head++;
      end
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    logic [31:0] prevAddr;
    logic [63:0] prevWd;
    bit          prevStall;
    int          cyc, tail;
    rqAddr[0]=32'h30000004; rqWr[0]=0; rqLong[0]=0; rqZone[0]=0; rqBeats[0]=1;
    rqAddr[1]=32'h38000010; rqWr[1]=0; rqLong[1]=0; rqZone[1]=0; rqBeats[1]=1;
    rqAddr[2]=32'h80001235; rqWr[2]=1; rqLong[2]=0; rqZone[2]=0; rqBeats[2]=1;
    rqAddr[3]=32'h00000100; rqWr[3]=1; rqLong[3]=0; rqZone[3]=0; rqBeats[3]=1;
    rqAddr[4]=32'h00000101; rqWr[4]=1; rqLong[4]=0; rqZone[4]=1; rqBeats[4]=1;
    rqAddr[5]=32'h38000020; rqWr[5]=1; rqLong[5]=1; rqZone[5]=0; rqBeats[5]=4;
    rqAddr[6]=32'h37FFFFFE; rqWr[6]=0; rqLong[6]=0; rqZone[6]=0; rqBeats[6]=4;
    rqAddr[7]=32'hC0000000; rqWr[7]=0; rqLong[7]=1; rqZone[7]=0; rqBeats[7]=2;
    rqAddr[8]=32'h30000003; rqWr[8]=1; rqLong[8]=0; rqZone[8]=0; rqBeats[8]=3;
    rqAddr[9]=32'h00000201; rqWr[9]=1; rqLong[9]=0; rqZone[9]=1; rqBeats[9]=2;

    rstN = 0; reqValid = 0; reqAddr = '0; reqWrite = 0; reqLong = 0;
    reqZone32 = 0; reqBeats = '0; reqWdata = '0; busRdata = '0; busAck = 1;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "reqReady", 64'(reqReady), 64'd1);
    chk("R12", "strobes", 64'({busRd, busWrLo, busWrHi, busBurst, busHost}), 64'd0);
    chk("R12", "busBank", 64'(busBank), 64'd0);
    chk("R12", "busAddr", 64'(busAddr), 64'd0);
    chk("R12", "rsp", 64'({rspValid, rspLast, wrPull}), 64'd0);
    rstN = 1;

    lfsr = 16'hACE1; prevStall = 0; prevAddr = '0; prevWd = '0; tail = 0;
    for (cyc = 0; cyc < 5000; cyc++) begin
      @(negedge clk);
      compareAll();
      if (mFirst) // R3: address and strobes appear together right after acceptance
        chk("R3", "strobe with address", 64'({(busRd | busWrLo | busWrHi), busAddr}),
            64'({1'b1, rqAddr[curIdx]}));
      if (prevStall) begin // R7: wait state held everything
        chk("R7", "addr held", 64'(busAddr), 64'(prevAddr));
        chk("R7", "wdata held", busWdata, prevWd);
      end
      if (head >= NReq && !mBusy && !mRv) begin
        tail++;
        if (tail > 2) break;
      end
      // drive inputs
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      busAck = (lfsr[1:0] != 2'b00);
      busRdata = {32'hBEEF0000 | 32'(cyc), ~32'(cyc)};
      reqValid = (head < NReq);
      if (head < NReq) begin
        reqAddr = rqAddr[head]; reqWrite = rqWr[head]; reqLong = rqLong[head];
        reqZone32 = rqZone[head]; reqBeats = 4'(rqBeats[head] - 1);
      end
      reqWdata = (mBusy && mWr) ? wd(curIdx, mBeat + 1) : wd(head, 0);
      #1;
      chk("R11", "wrPull", 64'(wrPull), 64'(mBusy && busAck && mLeft != 0 && mWr));
      prevStall = mBusy && !busAck;
      prevAddr = busAddr;
      prevWd = busWdata;
      modelStep();
    end
    if (cyc >= 5000) begin
      fails++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 5000);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule